// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives a bus controller access to a bank of byte-wide configuration registers. SCL and SDA are taken in through two-flop synchronizers on a faster system clock. START, STOP and the SCL edges are found by comparing each synchronized sample with the sample one cycle earlier, so the whole protocol engine runs in the system clock domain.

The device address has seven bits. The upper part is a fixed parameter. The two lowest bits come from strap pins, which are captured while reset is held. After a matching write address, the first byte is a pointer byte. Its top bit turns on auto-increment and its low seven bits select a register. Each byte that follows is written through a simple register-file port. A read transfer sends out the register at the current pointer. To choose which register a read starts from, the controller sends a write that carries only the pointer byte and ends it with STOP or a repeated START. The pointer survives both.

SDA is driven only as an active-high pull-down enable. The register file outside the block answers `reg_rdata` combinationally for the address on `reg_addr`.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset `sda_oe` and `reg_we` are 0. A START (SDA falling while SCL is high) begins address reception. A STOP (SDA rising while SCL is high) returns the block to idle with `sda_oe` at 0.
- R2: The first byte after a START is the address in bits 7:1 and a read flag in bit 0 (1 = read). The address matches when bits 7:3 equal the fixed high part (default 10011) and bits 2:1 equal the latched straps. On a match the block pulls SDA low for the ninth clock.
- R3: On a mismatching address the block gives no ACK. SDA then stays released, and nothing is written, until the next START.
- R4: `strap_i` is captured only while `rst_n` is low. Later changes to it do not alter the address that is matched.
- R5: In a write transfer the byte after the address is the pointer byte: bit 7 is the auto-increment enable and bits 6:0 are the register index. It is acknowledged.
- R6: Every later byte of a write is acknowledged and written. `reg_we` is high for exactly one system clock, with `reg_addr` set to the pointer and `reg_wdata` set to the byte.
- R7: With auto-increment the pointer advances by one after each byte written or sent, and wraps from 127 to 0. Without auto-increment the pointer does not move.
- R8: A read transfer sends the register at the pointer, MSB first. Each further byte the controller ACKs comes from the next register when auto-increment is on, and from the same register when it is off.
- R9: When the controller answers a sent byte with NACK, the block releases SDA and drives nothing until a STOP or START.
- R10: The pointer and the auto-increment flag are kept across STOP and repeated START. A write aborted after the pointer byte therefore sets where the next read begins.
- R11: `sda_oe` changes only in response to an SCL falling edge, a START or a STOP. An ACK is released on the SCL fall that ends the ACK clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset; straps are sampled while it is low |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| strap_i | input | 2 | Low device-address bits |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 7 | Register index, always the current pointer |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
The bench builds the block with its default parameters: a five-bit fixed address part, two strap bits, a seven-bit pointer and two synchronizer stages. With a seven-bit pointer, the wrap from 127 to 0 is reached by a three-byte auto-increment burst that starts at index 126. Both the write path and the read path cross that wrap. With two straps, one changed strap pattern after reset is enough to show that the latched address holds while the new pattern is refused.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } tgt_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } byte_kind_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LINES = 2;
  localparam int SCL_IX = 1;
  localparam int SDA_IX = 0;

  logic [LINES-1:0] raw, syn, prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[g]), .q(syn[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= syn;
  end

  assign sda_s     = syn[SDA_IX];
  assign scl_rise  =  syn[SCL_IX] & ~prev[SCL_IX];
  assign scl_fall  = ~syn[SCL_IX] &  prev[SCL_IX];
  assign start_evt =  syn[SCL_IX] &  prev[SCL_IX] &  prev[SDA_IX] & ~syn[SDA_IX];
  assign stop_evt  =  syn[SCL_IX] &  prev[SCL_IX] & ~prev[SDA_IX] &  syn[SDA_IX];

  // R1: a START and a STOP never coincide, and neither happens at an SCL edge
  p_evt_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |-> !(scl_rise || scl_fall) && !(start_evt && stop_evt));
endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit #(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             load_inc,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr,
  output logic             inc
);
  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p, input logic en);
    return en ? p + PTR_W'(1) : p;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      inc <= 1'b0;
    end else if (load) begin
      ptr <= load_val;
      inc <= load_inc;
    end else if (adv) begin
      ptr <= next_ptr(ptr, inc);
    end
  end

  // R7: the pointer wraps from its top value to zero
  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && inc && (&ptr)) |=> (ptr == '0));
  // R7: without auto-increment the pointer holds
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !inc) |=> (ptr == $past(ptr)));
  // R10: the pointer moves only on a load or an advance
  p_ptr_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> (ptr == $past(ptr)));
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter int                HI_W        = 5,
  parameter logic [HI_W-1:0]   ADDR_HI     = 5'b10011,
  parameter int                STRAP_W     = 2,
  parameter int                PTR_W       = 7,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe,
  output logic [PTR_W-1:0]   reg_addr,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic               reg_we,
  input  logic [DATA_W-1:0]  reg_rdata
);
  localparam int DEV_W = HI_W + STRAP_W;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W - 1);

  function automatic logic addr_hit(input logic [DATA_W-1:0] b, input logic [DEV_W-1:0] dev);
    return b[DATA_W-1 -: DEV_W] == dev;
  endfunction

  // bus events
  logic sda_s, scl_rise_w, scl_fall_w, start_w, stop_w;

  i2c_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_evt(start_w), .stop_evt(stop_w)
  );

  // straps captured while reset is held
  logic [STRAP_W-1:0] strap_q;
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_i;
  end
  logic [DEV_W-1:0] dev_addr;
  assign dev_addr = {ADDR_HI, strap_q};

  // protocol state
  tgt_state_e        state;
  byte_kind_e        kind;
  logic              rw, byte_done, hi_seen, mack, sda_oe_q, we_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;

  // named internal events
  logic byte_end_w, ack_end_w, tx_more_w, ptr_load_w, ptr_adv_w;
  assign byte_end_w = (state == ST_RX) && scl_fall_w && byte_done;
  assign ack_end_w  = scl_fall_w && hi_seen && (state == ST_RX_ACK || state == ST_TX_ACK);
  assign tx_more_w  = (state == ST_TX_ACK) && ack_end_w && mack;
  assign ptr_load_w = byte_end_w && (kind == K_PTR);
  assign ptr_adv_w  = tx_more_w ||
                      ((state == ST_RX_ACK) && ack_end_w &&
                       (kind == K_DATA || (kind == K_ADDR && rw)));

  logic [PTR_W-1:0] ptr;
  logic             ptr_inc;

  i2c_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(ptr_load_w), .load_val(shreg[PTR_W-1:0]), .load_inc(shreg[DATA_W-1]),
    .adv(ptr_adv_w), .ptr(ptr), .inc(ptr_inc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR;
      rw        <= 1'b0;
      byte_done <= 1'b0;
      hi_seen   <= 1'b0;
      mack      <= 1'b0;
      sda_oe_q  <= 1'b0;
      we_q      <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_w) begin
        state     <= ST_RX;
        kind      <= K_ADDR;
        cnt       <= '0;
        byte_done <= 1'b0;
        hi_seen   <= 1'b0;
        sda_oe_q  <= 1'b0;
      end else if (stop_w) begin
        state    <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise_w && !byte_done) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + CNT_W'(1);
              if (cnt == CNT_MAX) byte_done <= 1'b1;
            end else if (byte_end_w) begin
              byte_done <= 1'b0;
              cnt       <= '0;
              hi_seen   <= 1'b0;
              unique case (kind)
                K_ADDR: begin
                  if (addr_hit(shreg, dev_addr)) begin
                    sda_oe_q <= 1'b1;
                    rw       <= shreg[0];
                    state    <= ST_RX_ACK;
                  end else begin
                    state <= ST_WAIT;
                  end
                end
                K_PTR: begin
                  sda_oe_q <= 1'b1;
                  state    <= ST_RX_ACK;
                end
                default: begin
                  we_q     <= 1'b1;
                  sda_oe_q <= 1'b1;
                  state    <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_rise_w) begin
              hi_seen <= 1'b1;
            end else if (ack_end_w) begin
              hi_seen <= 1'b0;
              cnt     <= '0;
              if (kind == K_ADDR && rw) begin
                shreg    <= reg_rdata;
                sda_oe_q <= ~reg_rdata[DATA_W-1];
                state    <= ST_TX;
              end else begin
                sda_oe_q <= 1'b0;
                kind     <= (kind == K_ADDR) ? K_PTR : K_DATA;
                state    <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_w) begin
              if (cnt == CNT_MAX) begin
                sda_oe_q <= 1'b0;
                hi_seen  <= 1'b0;
                state    <= ST_TX_ACK;
              end else begin
                shreg    <= {shreg[DATA_W-2:0], 1'b0};
                sda_oe_q <= ~shreg[DATA_W-2];
                cnt      <= cnt + CNT_W'(1);
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_w) begin
              hi_seen <= 1'b1;
              mack    <= ~sda_s;
            end else if (ack_end_w) begin
              hi_seen <= 1'b0;
              if (mack) begin
                shreg    <= reg_rdata;
                sda_oe_q <= ~reg_rdata[DATA_W-1];
                cnt      <= '0;
                state    <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = sda_oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = shreg;
  assign reg_addr  = ptr;

  // R1: a STOP leaves the block idle with SDA released
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> (state == ST_IDLE) && !sda_oe);
  // R1: a START always begins address reception
  p_start_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (state == ST_RX) && (kind == K_ADDR));
  // R3, R9: while waiting for the next START or STOP, SDA is not driven
  p_wait_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_oe);
  // R4: the latched straps never change after reset
  p_strap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (strap_q == $past(strap_q)));
  // R6: the write strobe lasts one cycle
  p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  // R6: writes come only from data bytes, during their ACK
  p_we_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (kind == K_DATA) && (state == ST_RX_ACK) && sda_oe);
  // R11: the SDA drive moves only on an SCL fall, a START or a STOP
  p_oe_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall_w || start_w || stop_w));
endmodule

// File: tb/sim_i2c_cfg_target.sv
module sim_i2c_cfg_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [7:0] AW = 8'h9C;
  localparam logic [7:0] AR = 8'h9D;
  localparam logic [7:0] ABAD = 8'h9A;
  localparam int NVEC = 6;
  localparam logic [14:0] VEC [NVEC] = '{
    {7'd3,   8'hA5}, {7'd0,  8'h00}, {7'd127, 8'hFF},
    {7'd64,  8'h3C}, {7'd17, 8'h81}, {7'd100, 8'h5A}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] regs [128];
  int n_tests = 0, n_fail = 0, wcount = 0, wide_we = 0;
  logic prev_we = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = regs[reg_addr];

  i2c_cfg_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    prev_we <= reg_we;
    if (reg_we && prev_we) wide_we <= wide_we + 1;
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) regs[i] <= 8'(i) ^ 8'h5A;
    end else if (reg_we) begin
      regs[reg_addr] <= reg_wdata;
      wcount <= wcount + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; waitq();
    scl = 1'b1; waitq();
    r = sda_line; waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitq();
    scl = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitq();
    scl = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack, output logic rel);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
    rel = sda_line;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
    clk_bit(~give_ack, r);
  endtask

  task automatic read_at(input logic [6:0] p, output logic [7:0] b);
    logic a, rl;
    i2c_start(); wbyte(AW, a, rl); wbyte({1'b0, p}, a, rl); i2c_stop();
    i2c_start(); wbyte(AR, a, rl);
    chk("R2 read address ack", a, 1'b1);
    rbyte(1'b0, b); i2c_stop();
  endtask

  initial begin
    logic a, rl;
    logic [7:0] d;
    int wc;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 sda_oe after reset", sda_oe, 1'b0);
    chk("R1 reg_we after reset", reg_we, 1'b0);

    // table of single-byte writes and readbacks (R2, R5, R6, R8, R10)
    for (int v = 0; v < NVEC; v++) begin
      i2c_start();
      wbyte(AW, a, rl);           chk("R2 write address ack", a, 1'b1);
      wbyte({1'b0, VEC[v][14:8]}, a, rl); chk("R5 pointer ack", a, 1'b1);
      wbyte(VEC[v][7:0], a, rl);  chk("R6 data ack", a, 1'b1);
      i2c_stop();
      read_at(VEC[v][14:8], d);
      chk("R8 R10 readback", d, VEC[v][7:0]);
    end

    // R3 mismatching address: no ACK, no drive, no write
    wc = wcount;
    i2c_start();
    wbyte(ABAD, a, rl); chk("R3 no ack on wrong address", a, 1'b0);
    wbyte(8'h00, a, rl); chk("R3 SDA released after mismatch", a, 1'b0);
    i2c_stop();
    chk("R3 no write after mismatch", wcount, wc);

    // R4 strap change after reset is ignored
    strap = 2'b01;
    i2c_start();
    wbyte(ABAD, a, rl); chk("R4 new strap pattern refused", a, 1'b0);
    i2c_stop();
    i2c_start();
    wbyte(AW, a, rl); chk("R4 latched strap still matches", a, 1'b1);
    chk("R11 ack released after ack clock", rl, 1'b1);
    i2c_stop();

    // R7 auto-increment burst across the wrap, read back via repeated START
    i2c_start();
    wbyte(AW, a, rl); wbyte({1'b1, 7'd126}, a, rl);
    wbyte(8'h11, a, rl); wbyte(8'h22, a, rl); wbyte(8'h33, a, rl);
    chk("R6 burst data ack", a, 1'b1);
    i2c_stop();
    i2c_start();
    wbyte(AW, a, rl); wbyte({1'b1, 7'd126}, a, rl);
    i2c_start();
    wbyte(AR, a, rl); chk("R10 read after repeated START ack", a, 1'b1);
    rbyte(1'b1, d); chk("R8 burst byte 126", d, 8'h11);
    rbyte(1'b1, d); chk("R8 burst byte 127", d, 8'h22);
    rbyte(1'b0, d); chk("R7 wrap to register 0", d, 8'h33);
    i2c_stop();

    // R7 no auto-increment: both bytes land in register 5
    wc = wcount;
    i2c_start();
    wbyte(AW, a, rl); wbyte({1'b0, 7'd5}, a, rl);
    wbyte(8'h44, a, rl); wbyte(8'h55, a, rl);
    i2c_stop();
    chk("R6 two write strobes", wcount - wc, 2);

    // R10 pointer kept across STOP; R8 repeat without increment; R9 NACK release
    i2c_start();
    wbyte(AR, a, rl);
    rbyte(1'b1, d); chk("R10 read uses kept pointer", d, 8'h55);
    rbyte(1'b0, d); chk("R8 same register without increment", d, 8'h55);
    wc = 0;
    for (int k = 0; k < 9; k++) begin
      logic r;
      clk_bit(1'b1, r);
      if (!r) wc++;
    end
    chk("R9 SDA released after NACK", wc, 0);
    i2c_stop();
    read_at(7'd6, d);
    chk("R7 neighbour register untouched", d, 8'h5C);

    chk("R6 write strobe one cycle wide", wide_we, 0);
    chk("R1 idle after final STOP", sda_oe, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule